// File: doc/BRIEF.md
# Chainable Serial-In LED Channel Latch

This block is the digital front end of a sixteen-channel LED sink driver. A bit stream arrives on one data pin and is sampled on each rising edge of the system clock into a shift chain. A hold register takes its contents from that chain while the capture strobe is high. A gate input, active low, then turns the stored bits into per-channel "sink current" commands. Current setting and all other analog behaviour lie outside the block.

The last stage of the chain is presented on a serial output for the next device in a daisy chain. That output is retimed onto the falling clock edge. The downstream part therefore sees data that stays still for half a period on each side of its own rising sampling edge. Several devices connected output-to-input act as one long shift chain, and the bit shifted in first is the first to leave the far end.

The chain width and the edge used for the serial output are parameters. The default is sixteen channels with falling-edge retiming.

Top module: `led_sipo_drv`

## Requirements
- R1: On every rising clock edge outside reset, each chain bit moves one place toward the highest index (bit 15 at the default width), and bit 0 takes the value of `ser_in`.
- R2: While `cap_en` is high at a rising edge, the hold register loads the chain contents as they stand after that same edge, so `chan_on` shows the new shift at once when `blank_n` is low.
- R3: While `cap_en` is low at a rising edge, the hold register, and with it `chan_on`, stays unchanged whatever is shifted.
- R4: `chan_on[i]` is 1 (channel i sinks current) exactly when stored bit i is 1 and `blank_n` is 0. When `blank_n` is 1, all channel outputs are 0 in the same cycle.
- R5: `ser_out` carries the highest chain bit and changes only at falling clock edges. Just after a rising edge it still shows the value the highest bit had before that edge.
- R6: Two instances chained `ser_out` to `ser_in` act as one 32-bit chain. After 32 shifts of a word sent most significant bit first, the far device holds word bits 31..16 and the near device holds bits 15..0, each on channel index equal to the bit position minus its offset.
- R7: A synchronous active-high `rst` clears the chain and the hold register at a rising edge and clears `ser_out` at the following falling edge, so all channels read 0.
- R8: `blank_n` does not alter stored data. Channels blanked and then re-enabled show the same pattern as before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; data sampled on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data into chain bit 0 |
| cap_en | input | 1 | High: hold register follows the chain |
| blank_n | input | 1 | Active-low channel output enable |
| chan_on | output | 16 | Per-channel sink command, 1 = on |
| ser_out | output | 1 | Highest chain bit, retimed to falling edge |

## Verification
Two chained instances are fed 32-bit words: alternating nibbles, a split of all-ones and all-zeros, a single bit at each end of both halves, and a mixed word. Mirrored or rotated ordering, a lost bit at the device boundary, or a swapped half each leave a distinct wrong channel map. The serial output is sampled just after each rising edge and again just after the falling edge, which separates falling-edge retiming from a direct or rising-edge path. Separate runs then hold the strobe open across consecutive shifts, close it during a full word, and blank and restore the channels. These tell transparent capture apart from a one-cycle-late load, and gating apart from clearing the storage.

// File: rtl/led_sipo_pkg.sv
package led_sipo_pkg;

   // Edge on which the serial output of the chain is updated
   typedef enum logic {
      SO_FALL = 1'b0,
      SO_RISE = 1'b1
   } so_mode_e;

   localparam int unsigned DEF_CHANNELS = 16;
   localparam int unsigned MIN_CHANNELS = 2;

endpackage

// File: rtl/lsd_shift_stage.sv
module lsd_shift_stage #(
   parameter int unsigned WIDTH = led_sipo_pkg::DEF_CHANNELS
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ser_in,
   output logic [WIDTH-1:0] shift_q,
   output logic [WIDTH-1:0] shift_nxt
);

   localparam int unsigned TOP = WIDTH - 1;

   // next chain value: move toward the top index, new bit at 0
   always_comb begin
      shift_nxt = {shift_q[TOP-1:0], ser_in};
   end

   always_ff @(posedge clk) begin
      if (rst) shift_q <= '0;
      else     shift_q <= shift_nxt;
   end

endmodule

// File: rtl/lsd_hold_stage.sv
module lsd_hold_stage #(
   parameter int unsigned WIDTH = led_sipo_pkg::DEF_CHANNELS
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap_en,
   input  logic [WIDTH-1:0] shift_nxt,
   output logic [WIDTH-1:0] hold_q
);

   // clocked stand-in for a transparent latch: follows the chain
   // as it stands after this edge while the strobe is high
   always_ff @(posedge clk) begin
      if (rst)         hold_q <= '0;
      else if (cap_en) hold_q <= shift_nxt;
   end

endmodule

// File: rtl/lsd_out_stage.sv
module lsd_out_stage #(
   parameter int unsigned           WIDTH   = led_sipo_pkg::DEF_CHANNELS,
   parameter led_sipo_pkg::so_mode_e SO_MODE = led_sipo_pkg::SO_FALL
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             blank_n,
   input  logic             chain_msb,
   input  logic [WIDTH-1:0] hold_q,
   output logic [WIDTH-1:0] chan_on,
   output logic             ser_out
);

   logic so_q;

   always_comb begin
      chan_on = blank_n ? '0 : hold_q;
   end

   generate
      if (SO_MODE == led_sipo_pkg::SO_FALL) begin : g_so_fall
         always_ff @(negedge clk) begin
            if (rst) so_q <= 1'b0;
            else     so_q <= chain_msb;
         end
      end else begin : g_so_rise
         always_comb begin
            so_q = chain_msb;
         end
      end
   endgenerate

   assign ser_out = so_q;

endmodule

// File: rtl/led_sipo_drv.sv
module led_sipo_drv #(
   parameter int unsigned           WIDTH   = led_sipo_pkg::DEF_CHANNELS,
   parameter led_sipo_pkg::so_mode_e SO_MODE = led_sipo_pkg::SO_FALL
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ser_in,
   input  logic             cap_en,
   input  logic             blank_n,
   output logic [WIDTH-1:0] chan_on,
   output logic             ser_out
);

   localparam int unsigned TOP = WIDTH - 1;

   generate
      if (WIDTH < led_sipo_pkg::MIN_CHANNELS) begin : g_bad_width
         $error("led_sipo_drv: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] shift_q;
   logic [WIDTH-1:0] shift_nxt;
   logic [WIDTH-1:0] hold_q;

   lsd_shift_stage #(.WIDTH(WIDTH)) u_shift (
      .clk       (clk),
      .rst       (rst),
      .ser_in    (ser_in),
      .shift_q   (shift_q),
      .shift_nxt (shift_nxt)
   );

   lsd_hold_stage #(.WIDTH(WIDTH)) u_hold (
      .clk       (clk),
      .rst       (rst),
      .cap_en    (cap_en),
      .shift_nxt (shift_nxt),
      .hold_q    (hold_q)
   );

   lsd_out_stage #(.WIDTH(WIDTH), .SO_MODE(SO_MODE)) u_out (
      .clk       (clk),
      .rst       (rst),
      .blank_n   (blank_n),
      .chain_msb (shift_q[TOP]),
      .hold_q    (hold_q),
      .chan_on   (chan_on),
      .ser_out   (ser_out)
   );

endmodule

// File: rtl/led_sipo_drv_chk.sv
module led_sipo_drv_chk #(
   parameter int unsigned WIDTH = led_sipo_pkg::DEF_CHANNELS
) (
   input logic             clk,
   input logic             rst,
   input logic             ser_in,
   input logic             cap_en,
   input logic             blank_n,
   input logic [WIDTH-1:0] chan_on,
   input logic             ser_out,
   input logic [WIDTH-1:0] shreg,
   input logic [WIDTH-1:0] hold
);

   AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (shreg == {$past(shreg[WIDTH-2:0]), $past(ser_in)})); // R1

   AST_CAPTURE_OPEN: assert property (@(posedge clk) disable iff (rst)
      cap_en |=> (hold == shreg)); // R2

   AST_CAPTURE_CLOSED: assert property (@(posedge clk) disable iff (rst)
      !cap_en |=> $stable(hold)); // R3

   AST_BLANK_ALL: assert property (@(posedge clk) disable iff (rst)
      blank_n |-> (chan_on == '0)); // R4

   AST_SO_MSB: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (ser_out == shreg[WIDTH-1])); // R5

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (shreg == '0 && hold == '0)); // R7

endmodule

bind led_sipo_drv led_sipo_drv_chk #(.WIDTH(WIDTH)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .ser_in  (ser_in),
   .cap_en  (cap_en),
   .blank_n (blank_n),
   .chan_on (chan_on),
   .ser_out (ser_out),
   .shreg   (shift_q),
   .hold    (hold_q)
);

// File: tb/sim_led_sipo_drv.sv
`timescale 1ns/1ps
module sim_led_sipo_drv;

   localparam int NVEC = 5;
   localparam logic [31:0] VEC [NVEC] = '{
      32'hA5C3_0F96, 32'hFFFF_0000, 32'h8001_8001, 32'h1234_ABCD, 32'h0000_FFFF
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ser_in = 1'b0;
   logic        cap_en = 1'b0;
   logic        blank_n = 1'b0;
   logic [15:0] chan0, chan1;
   logic        so0, so1;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] model   = '0;
   logic [31:0] latched = '0;

   always #4 clk = ~clk;

   led_sipo_drv u0 (
      .clk(clk), .rst(rst), .ser_in(ser_in), .cap_en(cap_en),
      .blank_n(blank_n), .chan_on(chan0), .ser_out(so0)
   );

   led_sipo_drv u1 (
      .clk(clk), .rst(rst), .ser_in(so0), .cap_en(cap_en),
      .blank_n(blank_n), .chan_on(chan1), .ser_out(so1)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_chans(input string req);
      logic [31:0] exp;
      exp = blank_n ? 32'h0 : latched;
      check(req, {chan1, chan0}, exp);
   endtask

   // one shift; entered and left just after a falling edge
   task automatic step(input logic b, input logic le);
      logic old;
      ser_in = b;
      cap_en = le;
      old = model[31];
      @(posedge clk);
      model = {model[30:0], b};
      if (le) latched = model;
      #2;
      check("R5 ser_out before fall", {31'h0, so1}, {31'h0, old});
      @(negedge clk);
      #1;
      check("R5 ser_out after fall", {31'h0, so1}, {31'h0, model[31]});
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk);
      model = '0;
      latched = '0;
      @(negedge clk);
      #1;
      rst = 1'b0;
      check("R7 channels clear", {chan1, chan0}, 32'h0);
      check("R7 ser_out clear", {30'h0, so1, so0}, 32'h0);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      do_reset();

      // table walk: word sent msb first, strobe on the last bit only
      for (int v = 0; v < NVEC; v++) begin
         for (int i = 0; i < 31; i++) step(VEC[v][31-i], 1'b0);
         check_chans("R3 held during shift");
         step(VEC[v][0], 1'b1);
         check("R6 chain split", {chan1, chan0}, VEC[v]);
         check("R2 capture", {chan1, chan0}, latched);
      end

      // strobe open across consecutive shifts: outputs track each edge
      for (int i = 0; i < 4; i++) begin
         step(i[0], 1'b1);
         check_chans("R2 follow each edge");
         check("R1 shift toward top", {chan1, chan0}, model);
      end

      // closed strobe while shifting a different word
      for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
      check_chans("R3 closed strobe holds");

      // blanking
      blank_n = 1'b1;
      #1;
      check("R4 blank forces off", {chan1, chan0}, 32'h0);
      step(1'b0, 1'b0);
      check("R4 blank while shifting", {chan1, chan0}, 32'h0);
      blank_n = 1'b0;
      #1;
      check("R8 data kept through blank", {chan1, chan0}, latched);

      // reset after data is present
      do_reset();
      step(1'b1, 1'b1);
      check("R1 first bit lands at bit0", {chan1, chan0}, 32'h1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule